// File: doc/BRIEF.md
# Iterative Multiply-Divide Unit with High/Low Result Registers

This unit performs 32-bit multiplication and division, in both signed and unsigned forms. It keeps each result in a pair of result registers, HI and LO. A one-cycle start pulse carries two operands and a 2-bit operation code. The unit then spends one setup cycle forming operand magnitudes. After that it runs a radix-2 engine for one step per operand bit: shift-and-add for a product, restoring shift-and-subtract for a quotient. It corrects the signs in the same cycle that it commits the result. A busy flag covers the whole operation.

A multiply puts the 64-bit product across the pair, with the upper word in HI and the lower word in LO. A divide puts the quotient in LO and the remainder in HI. Signed division truncates toward zero, and the remainder takes the sign of the dividend. Division by zero never traps.

Software-visible moves into HI or LO are accepted when the unit is idle. Reads are signalled through read-enable inputs, and a stall output tells the consumer to wait while a computation is in flight. Pseudo-operations that detect overflow are built outside this unit.

Top module: `muldiv_hilo`

## Requirements
- R1: A start pulse sampled while idle raises busy on the next cycle. Busy then stays high for exactly WIDTH+1 cycles (33 by default), and HI and LO take their new values in the cycle that busy falls. Operation codes: 2'b00 signed multiply, 2'b01 unsigned multiply, 2'b10 signed divide, 2'b11 unsigned divide.
- R2: Unsigned multiply treats both operands as unsigned. It leaves bits 31:0 of the 64-bit product in LO and bits 63:32 in HI.
- R3: Signed multiply treats both operands as two's complement and splits the 64-bit signed product the same way as R2.
- R4: Unsigned divide leaves the quotient in LO and the remainder in HI.
- R5: Signed divide truncates the quotient toward zero, and the remainder carries the sign of the dividend. The most negative value divided by -1 gives LO = 32'h8000_0000 and HI = 0.
- R6: A divide by zero, signed or unsigned, takes the normal latency. It leaves LO = 32'hFFFF_FFFF and HI equal to the dividend as given.
- R7: A start pulse while busy is ignored. The running operation's result and its latency are unchanged.
- R8: When idle, a move to HI or a move to LO writes the data input into that register on the next cycle. While busy, moves have no effect.
- R9: rd_stall is high whenever a read enable is high while busy, and low otherwise. hi_rdata and lo_rdata always present HI and LO.
- R10: After reset, HI and LO are zero, busy is low and rd_stall is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse for a new operation |
| op | input | 2 | Operation code (see R1) |
| opa | input | WIDTH | Multiplicand or dividend |
| opb | input | WIDTH | Multiplier or divisor |
| busy | output | 1 | Computation in progress |
| mt_hi | input | 1 | Move data into HI |
| mt_lo | input | 1 | Move data into LO |
| mt_data | input | WIDTH | Data for the move |
| rd_hi_en | input | 1 | Read request for HI |
| rd_lo_en | input | 1 | Read request for LO |
| rd_stall | output | 1 | Read must wait |
| hi_rdata | output | WIDTH | HI contents |
| lo_rdata | output | WIDTH | LO contents |

## Verification
Each operation runs on operand pairs whose signs are mixed in every combination. The mixed-sign cases separate correct sign fixup from plain magnitude arithmetic. Products with large magnitudes force carries into HI, which exposes a wrong word split or a missing carry. The boundary cases are division by zero, the most negative value divided by -1 and dividends smaller than their divisors, and each probes a corner of the restoring loop. A start pulse and moves injected mid-operation show whether in-flight state stays shielded, and the busy length is counted on every operation.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
    typedef enum logic [1:0] {
        OP_MULS = 2'b00,
        OP_MULU = 2'b01,
        OP_DIVS = 2'b10,
        OP_DIVU = 2'b11
    } md_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_SETUP = 2'b01,
        ST_RUN   = 2'b10
    } md_state_e;
endpackage

// File: rtl/muldiv_step.sv
module muldiv_step #(
    parameter int WIDTH = 32
) (
    input  logic               is_div,
    input  logic [2*WIDTH-1:0] acc_i,
    input  logic [WIDTH-1:0]   m_i,
    output logic [2*WIDTH-1:0] acc_o
);
    logic [WIDTH:0] sum;
    logic [WIDTH:0] shifted;
    logic [WIDTH:0] diff;
    logic           ge;

    always_comb begin
        sum     = {1'b0, acc_i[2*WIDTH-1:WIDTH]} + (acc_i[0] ? {1'b0, m_i} : '0);
        shifted = {acc_i[2*WIDTH-1:WIDTH], acc_i[WIDTH-1]};
        diff    = shifted - {1'b0, m_i};
        ge      = ~diff[WIDTH];
        if (is_div) begin
            acc_o = {(ge ? diff[WIDTH-1:0] : shifted[WIDTH-1:0]), acc_i[WIDTH-2:0], ge};
        end else begin
            acc_o = {sum, acc_i[WIDTH-1:1]};
        end
    end
endmodule

// File: rtl/muldiv_fixup.sv
module muldiv_fixup
    import muldiv_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  md_op_e             op,
    input  logic [WIDTH-1:0]   a_raw,
    input  logic [WIDTH-1:0]   b_raw,
    input  logic [2*WIDTH-1:0] acc,
    output logic [WIDTH-1:0]   hi,
    output logic [WIDTH-1:0]   lo
);
    logic              sgn, a_neg, b_neg;
    logic [2*WIDTH-1:0] prod;

    always_comb begin
        sgn   = (op == OP_MULS) || (op == OP_DIVS);
        a_neg = sgn & a_raw[WIDTH-1];
        b_neg = sgn & b_raw[WIDTH-1];
        prod  = (a_neg ^ b_neg) ? (~acc + 1'b1) : acc;
        if (op == OP_MULS || op == OP_MULU) begin
            hi = prod[2*WIDTH-1:WIDTH];
            lo = prod[WIDTH-1:0];
        end else if (b_raw == '0) begin
            hi = a_raw;
            lo = '1;
        end else begin
            hi = a_neg ? (~acc[2*WIDTH-1:WIDTH] + 1'b1) : acc[2*WIDTH-1:WIDTH];
            lo = (a_neg ^ b_neg) ? (~acc[WIDTH-1:0] + 1'b1) : acc[WIDTH-1:0];
        end
    end
endmodule

// File: rtl/muldiv_hilo.sv
module muldiv_hilo
    import muldiv_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [1:0]       op,
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    output logic             busy,
    input  logic             mt_hi,
    input  logic             mt_lo,
    input  logic [WIDTH-1:0] mt_data,
    input  logic             rd_hi_en,
    input  logic             rd_lo_en,
    output logic             rd_stall,
    output logic [WIDTH-1:0] hi_rdata,
    output logic [WIDTH-1:0] lo_rdata
);
    localparam int CW = $clog2(WIDTH);
    localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

    typedef struct packed {
        md_state_e          st;
        logic [CW-1:0]      cnt;
        md_op_e             op;
        logic [WIDTH-1:0]   a;
        logic [WIDTH-1:0]   b;
        logic [WIDTH-1:0]   m;
        logic [2*WIDTH-1:0] acc;
        logic [WIDTH-1:0]   hi;
        logic [WIDTH-1:0]   lo;
    } md_reg_t;

    md_reg_t            r_d, r_q;
    logic [2*WIDTH-1:0] step_acc;
    logic [WIDTH-1:0]   fix_hi, fix_lo;
    logic               busy_q;

    muldiv_step #(.WIDTH(WIDTH)) u_step (
        .is_div (r_q.op[1]),
        .acc_i  (r_q.acc),
        .m_i    (r_q.m),
        .acc_o  (step_acc)
    );

    muldiv_fixup #(.WIDTH(WIDTH)) u_fixup (
        .op    (r_q.op),
        .a_raw (r_q.a),
        .b_raw (r_q.b),
        .acc   (step_acc),
        .hi    (fix_hi),
        .lo    (fix_lo)
    );

    always_comb begin
        logic             sgn;
        logic [WIDTH-1:0] mag_a, mag_b;
        r_d   = r_q;
        sgn   = ~r_q.op[0];
        mag_a = (sgn && r_q.a[WIDTH-1]) ? (~r_q.a + 1'b1) : r_q.a;
        mag_b = (sgn && r_q.b[WIDTH-1]) ? (~r_q.b + 1'b1) : r_q.b;
        unique case (r_q.st)
            ST_IDLE: begin
                if (mt_hi) r_d.hi = mt_data;
                if (mt_lo) r_d.lo = mt_data;
                if (start) begin
                    r_d.st = ST_SETUP;
                    r_d.op = md_op_e'(op);
                    r_d.a  = opa;
                    r_d.b  = opb;
                end
            end
            ST_SETUP: begin
                r_d.st  = ST_RUN;
                r_d.cnt = '0;
                if (r_q.op[1]) begin
                    r_d.m   = mag_b;
                    r_d.acc = {{WIDTH{1'b0}}, mag_a};
                end else begin
                    r_d.m   = mag_a;
                    r_d.acc = {{WIDTH{1'b0}}, mag_b};
                end
            end
            ST_RUN: begin
                r_d.acc = step_acc;
                r_d.cnt = r_q.cnt + 1'b1;
                if (r_q.cnt == LAST) begin
                    r_d.st = ST_IDLE;
                    r_d.hi = fix_hi;
                    r_d.lo = fix_lo;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, op: OP_MULS, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_q   = (r_q.st != ST_IDLE);
    assign busy     = busy_q;
    assign rd_stall = busy_q & (rd_hi_en | rd_lo_en);
    assign hi_rdata = r_q.hi;
    assign lo_rdata = r_q.lo;

    // Checker-side busy length counter
    logic [CW+1:0] bcnt_q;
    always_ff @(posedge clk) begin
        if (!rst_n)      bcnt_q <= '0;
        else if (busy_q) bcnt_q <= bcnt_q + 1'b1;
        else             bcnt_q <= '0;
    end

    // R1
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R1
    busy_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (bcnt_q == (CW+2)'(WIDTH + 1)));

    // R7
    hold_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy -> ($stable(hi_rdata) && $stable(lo_rdata))));

    // R8
    move_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && mt_hi) |=> (hi_rdata == $past(mt_data)));

    // R8
    move_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && mt_lo) |=> (lo_rdata == $past(mt_data)));
endmodule

// File: tb/muldiv_hilo_bench.sv
module muldiv_hilo_bench;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [1:0]   op = 2'b00;
    logic [W-1:0] opa = '0, opb = '0;
    logic         busy;
    logic         mt_hi = 1'b0, mt_lo = 1'b0;
    logic [W-1:0] mt_data = '0;
    logic         rd_hi_en = 1'b0, rd_lo_en = 1'b0;
    logic         rd_stall;
    logic [W-1:0] hi_rdata, lo_rdata;

    int checks = 0;
    int failures = 0;

    logic [63:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    muldiv_hilo #(.WIDTH(W)) u_muldiv_hilo (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .opa(opa), .opb(opb),
        .busy(busy), .mt_hi(mt_hi), .mt_lo(mt_lo), .mt_data(mt_data),
        .rd_hi_en(rd_hi_en), .rd_lo_en(rd_lo_en), .rd_stall(rd_stall),
        .hi_rdata(hi_rdata), .lo_rdata(lo_rdata)
    );

    task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] model(input logic [1:0] o, input logic [W-1:0] a, input logic [W-1:0] b);
        logic signed [63:0] sa, sb, q, r;
        logic        [63:0] p;
        sa = {{32{a[31]}}, a};
        sb = {{32{b[31]}}, b};
        case (o)
            2'b01:   p = {32'b0, a} * {32'b0, b};
            2'b00:   p = sa * sb;
            2'b11:   p = (b == 0) ? {a, 32'hFFFF_FFFF} : {a % b, a / b};
            default: begin
                if (b == 0) p = {a, 32'hFFFF_FFFF};
                else begin
                    q = sa / sb;
                    r = sa % sb;
                    p = {r[31:0], q[31:0]};
                end
            end
        endcase
        return p;
    endfunction

    // Monitor: counts busy length and compares results as busy falls
    int  bcycles = 0;
    logic prev_busy = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy) bcycles++;
            if (prev_busy && !busy) begin
                chk(bcycles == 33, "R1 busy length", 64'(bcycles), 64'd33);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R7 unexpected result", {hi_rdata, lo_rdata}, 64'h0);
                end else begin
                    logic [63:0] e;
                    string       t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk({hi_rdata, lo_rdata} == e, t, {hi_rdata, lo_rdata}, e);
                end
                bcycles = 0;
            end
            prev_busy = busy;
        end
    end

    task automatic launch(input logic [1:0] o, input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
        @(negedge clk);
        start = 1'b1; op = o; opa = a; opb = b;
        exp_q.push_back(model(o, a, b));
        tag_q.push_back(tag);
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R1 busy rises", 64'(busy), 64'd1);
    endtask

    task automatic finish_op();
        while (busy) @(negedge clk);
    endtask

    task automatic run_op(input logic [1:0] o, input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
        launch(o, a, b, tag);
        finish_op();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10
        chk(hi_rdata == 0 && lo_rdata == 0, "R10 reset HI/LO", {hi_rdata, lo_rdata}, 64'h0);
        chk(!busy && !rd_stall, "R10 reset busy/stall", {busy, rd_stall}, 64'h0);

        // R2
        run_op(2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R2 mulu max");
        run_op(2'b01, 32'h1234_5678, 32'h9ABC_DEF0, "R2 mulu mix");
        run_op(2'b01, 32'd0, 32'h8000_0001, "R2 mulu zero");
        // R3
        run_op(2'b00, 32'hFFFF_FFFD, 32'd7, "R3 muls neg*pos");
        run_op(2'b00, 32'hFFFF_FFF9, 32'hFFFF_FFFB, "R3 muls neg*neg");
        run_op(2'b00, 32'h8000_0000, 32'h8000_0000, "R3 muls min*min");
        run_op(2'b00, 32'h7FFF_FFFF, 32'h8000_0000, "R3 muls max*min");
        // R4
        run_op(2'b11, 32'd100, 32'd7, "R4 divu small");
        run_op(2'b11, 32'hFFFF_FFFF, 32'd3, "R4 divu big");
        run_op(2'b11, 32'd5, 32'hFFFF_FFF0, "R4 divu dividend<divisor");
        // R5
        run_op(2'b10, 32'hFFFF_FFF9, 32'd2, "R5 divs -7/2");
        run_op(2'b10, 32'd7, 32'hFFFF_FFFE, "R5 divs 7/-2");
        run_op(2'b10, 32'hFFFF_FFF9, 32'hFFFF_FFFE, "R5 divs -7/-2");
        run_op(2'b10, 32'h8000_0000, 32'hFFFF_FFFF, "R5 divs min/-1");
        // R6
        run_op(2'b11, 32'hDEAD_BEEF, 32'd0, "R6 divu by zero");
        run_op(2'b10, 32'hFFFF_FF85, 32'd0, "R6 divs by zero");

        // R7 and R8 and R9: interference while busy
        launch(2'b01, 32'd1000, 32'd3000, "R7 result kept");
        repeat (5) @(negedge clk);
        rd_hi_en = 1'b1;
        #1;
        chk(rd_stall == 1'b1, "R9 stall while busy", 64'(rd_stall), 64'd1);
        rd_hi_en = 1'b0; rd_lo_en = 1'b1;
        #1;
        chk(rd_stall == 1'b1, "R9 stall lo while busy", 64'(rd_stall), 64'd1);
        rd_lo_en = 1'b0;
        start = 1'b1; op = 2'b11; opa = 32'd9; opb = 32'd0;
        mt_hi = 1'b1; mt_lo = 1'b1; mt_data = 32'hA5A5_A5A5;
        @(negedge clk);
        start = 1'b0; mt_hi = 1'b0; mt_lo = 1'b0;
        finish_op();
        @(negedge clk);
        chk(!busy, "R7 no second run", 64'(busy), 64'd0);
        chk(hi_rdata == 0 && lo_rdata == 32'd3_000_000, "R8 move ignored when busy",
            {hi_rdata, lo_rdata}, {32'd0, 32'd3_000_000});

        // R9 idle read
        rd_hi_en = 1'b1; rd_lo_en = 1'b1;
        #1;
        chk(rd_stall == 1'b0, "R9 no stall idle", 64'(rd_stall), 64'd0);
        rd_hi_en = 1'b0; rd_lo_en = 1'b0;

        // R8 idle moves
        @(negedge clk);
        mt_hi = 1'b1; mt_data = 32'hCAFE_0001;
        @(negedge clk);
        mt_hi = 1'b0;
        chk(hi_rdata == 32'hCAFE_0001 && lo_rdata == 32'd3_000_000, "R8 move to HI",
            {hi_rdata, lo_rdata}, {32'hCAFE_0001, 32'd3_000_000});
        mt_lo = 1'b1; mt_data = 32'h0BAD_F00D;
        @(negedge clk);
        mt_lo = 1'b0;
        chk(hi_rdata == 32'hCAFE_0001 && lo_rdata == 32'h0BAD_F00D, "R8 move to LO",
            {hi_rdata, lo_rdata}, {32'hCAFE_0001, 32'h0BAD_F00D});

        // R1 back-to-back ops
        run_op(2'b00, 32'd12345, 32'hFFFF_0000, "R1 back to back a");
        run_op(2'b10, 32'h8000_0001, 32'd16, "R1 back to back b");

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R1 all results seen", 64'(exp_q.size()), 64'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule